// File: doc/BRIEF.md
# AUX Request Framer and Reply Decoder

This block sits between a requester that issues short auxiliary-channel transactions and a lower-level channel engine that moves bytes on the wire. A request carries a 4-bit command, a 16-bit address, a payload length and, for writes, a byte stream of payload data. The block checks the request and packs it into a four-byte header. For writes it then appends the payload. It hands the result to the engine as a byte stream with a valid/ready handshake.

When the engine completes, it reports a status byte and a reply byte. Any read bytes arrive on a simple valid strobe before that completion. The block forwards read bytes to the requester, never more than were asked for. It then reports a single result: an error class, the upper nibble of the reply byte and a byte count. Only one transaction is in flight at a time. The requester sees ready low from the cycle after acceptance until the result is reported.

Top module: `aux_req_framer`

## Requirements
- R1: A request whose length exceeds MAX_LEN (16) is accepted and rejected. No byte is emitted, and one cycle later the result reports error class 3 with count 0 and reply 0.
- R2: Header byte 0 is address[7:0] and byte 1 is address[15:8]. Byte 2 carries the full 4-bit command in bits 7:4 and zeros in bits 3:0.
- R3: Header byte 3 bits 3:0 hold length minus one, or 0 when the length is 0.
- R4: Header byte 3 bits 7:4 hold 3 when the length is 0. Otherwise they hold 4 for reads, and (4 + length) modulo 16 for writes, so a 16-byte write gives 4.
- R5: Writes emit the four header bytes and then the payload bytes in order. Reads, including zero-length ones, emit only the four header bytes.
- R6: A completion status of 1 gives error class 1 (timeout). Status 2 or 3 gives class 2 (I/O). Any other status gives class 0. res_err is high with res_valid exactly when the class is non-zero.
- R7: For a read, the bytes returned by the engine are forwarded on rd_valid/rd_data only up to the requested length; later bytes are dropped. A successful read reports the number forwarded as its count.
- R8: On success, res_reply is the reply byte shifted right by 4, and a write reports its requested length as the count. On any error, count and reply are 0.
- R9: The command is legal only if, with bit 2 (the middle-of-transaction flag) cleared, it is 0 or 8 (write) or 1 or 9 (read). Any other command is rejected like R1, with class 3 and no bytes emitted.
- R10: req_ready is low from the cycle after acceptance until the cycle in which res_valid is high. res_valid is a one-cycle pulse.
- R11: After reset, req_ready is 1 and tx_valid, rd_valid and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_cmd | input | 4 | Command code |
| req_addr | input | 16 | Target address |
| req_len | input | LEN_W (5) | Payload length in bytes |
| wr_valid | input | 1 | Write payload byte present |
| wr_ready | output | 1 | Write payload byte consumed |
| wr_data | input | 8 | Write payload byte |
| tx_valid | output | 1 | Byte toward the channel engine present |
| tx_ready | input | 1 | Engine accepts the byte |
| tx_data | output | 8 | Header or payload byte |
| eng_rx_valid | input | 1 | Engine returns a read byte |
| eng_rx_data | input | 8 | Returned read byte |
| eng_done | input | 1 | Engine completion strobe |
| eng_status | input | 8 | Completion status |
| eng_reply | input | 8 | Raw reply byte |
| rd_valid | output | 1 | Forwarded read byte present |
| rd_data | output | 8 | Forwarded read byte |
| res_valid | output | 1 | Result pulse |
| res_err | output | 1 | Result is an error |
| res_class | output | 2 | 0 none, 1 timeout, 2 I/O, 3 rejected |
| res_reply | output | 4 | Reply byte bits 7:4 |
| res_count | output | LEN_W (5) | Bytes transferred |

## Verification
The bench goes after the length nibble corner cases: zero-length packets of both kinds, and a 16-byte write whose total wraps to 4. A design that sent the total for reads, or skipped the address-only marker, would produce a wrong byte 3. Oversized lengths and illegal commands are sent with the middle-of-transaction flag both set and cleared. A design that rejected too late would leak header bytes, and one that failed to mask the flag would refuse legal I2C-over-AUX commands. Reads are answered with more bytes than asked for and with fewer. A missing clip would over-report the count and forward extra data. All four interesting status values are exercised, so a swapped error class or a non-zero count on failure shows up.

// File: rtl/aux_fr_pkg.sv
package aux_fr_pkg;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_IO      = 2'd2,
    ERR_REJECT  = 2'd3
  } err_class_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REJ,
    ST_HDR,
    ST_PAY,
    ST_WAIT
  } seq_st_e;

  // Legal commands once the middle-of-transaction bit (bit 2) is masked.
  function automatic logic cmd_is_legal(input logic [3:0] cmd);
    logic [3:0] m;
    m = cmd & 4'b1011;
    return (m == 4'h0) || (m == 4'h1) || (m == 4'h8) || (m == 4'h9);
  endfunction

  function automatic logic cmd_is_read(input logic [3:0] cmd);
    return cmd[0];
  endfunction

  // Length byte: upper nibble is the marker/total, lower nibble is size-1.
  function automatic logic [7:0] len_byte(input logic [7:0] len, input logic rd);
    logic [3:0] lo;
    logic [3:0] hi;
    if (len == 8'd0) begin
      lo = 4'd0;
      hi = 4'd3;
    end else begin
      lo = len[3:0] - 4'd1;
      hi = rd ? 4'd4 : (len[3:0] + 4'd4);
    end
    return {hi, lo};
  endfunction

  function automatic err_class_e status_class(input logic [7:0] st);
    case (st)
      8'd1:         return ERR_TIMEOUT;
      8'd2, 8'd3:   return ERR_IO;
      default:      return ERR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/aux_tx_seq.sv
module aux_tx_seq
  import aux_fr_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_cmd,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  input  logic             eng_done,
  output logic             ev_start,
  output logic             ev_reject,
  output logic             ev_waiting,
  output logic             rd_q,
  output logic [LEN_W-1:0] len_q
);

  localparam int HDR_BYTES = 4;
  localparam int HIDX_W    = $clog2(HDR_BYTES);

  seq_st_e           state_q;
  logic [3:0]        cmd_q;
  logic [15:0]       addr_q;
  logic [HIDX_W-1:0] hidx_q;
  logic [LEN_W-1:0]  pcnt_q;

  logic accept;
  logic bad_req;
  logic hdr_last;
  logic pay_last;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign bad_req   = !cmd_is_legal(req_cmd) || (int'(req_len) > MAX_LEN);
  assign req_ready = (state_q == ST_IDLE);
  assign hdr_last  = (hidx_q == HIDX_W'(HDR_BYTES - 1));
  assign pay_last  = (pcnt_q == len_q - LEN_W'(1));

  assign ev_start   = accept && !bad_req;
  assign ev_reject  = (state_q == ST_REJ);
  assign ev_waiting = (state_q == ST_WAIT);

  assign tx_valid = (state_q == ST_HDR) || ((state_q == ST_PAY) && wr_valid);
  assign wr_ready = (state_q == ST_PAY) && tx_ready;

  always_comb begin
    tx_data = wr_data;
    if (state_q == ST_HDR) begin
      case (hidx_q)
        2'd0:    tx_data = addr_q[7:0];
        2'd1:    tx_data = addr_q[15:8];
        2'd2:    tx_data = {cmd_q, 4'h0};
        default: tx_data = len_byte(8'(len_q), rd_q);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      rd_q    <= 1'b0;
      hidx_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          cmd_q   <= req_cmd;
          addr_q  <= req_addr;
          len_q   <= req_len;
          rd_q    <= cmd_is_read(req_cmd);
          hidx_q  <= '0;
          pcnt_q  <= '0;
          state_q <= bad_req ? ST_REJ : ST_HDR;
        end
        ST_REJ: state_q <= ST_IDLE;
        ST_HDR: if (tx_ready) begin
          hidx_q <= hidx_q + HIDX_W'(1);
          if (hdr_last)
            state_q <= (!rd_q && (len_q != '0)) ? ST_PAY : ST_WAIT;
        end
        ST_PAY: if (tx_ready && wr_valid) begin
          pcnt_q <= pcnt_q + LEN_W'(1);
          if (pay_last) state_q <= ST_WAIT;
        end
        ST_WAIT: if (eng_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a byte offered to the engine holds until it is taken
  a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && (state_q == ST_HDR)) |=> (tx_valid && $stable(tx_data)));

  // R5: payload bytes are only pulled for writes of non-zero length
  a_r5_pay_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!rd_q && (len_q != '0)));

endmodule

// File: rtl/aux_rx_dec.sv
module aux_rx_dec
  import aux_fr_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_reject,
  input  logic             ev_waiting,
  input  logic             rd_q,
  input  logic [LEN_W-1:0] len_q,
  input  logic             eng_rx_valid,
  input  logic [7:0]       eng_rx_data,
  input  logic             eng_done,
  input  logic [7:0]       eng_status,
  input  logic [7:0]       eng_reply,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             res_valid,
  output logic             res_err,
  output logic [1:0]       res_class,
  output logic [3:0]       res_reply,
  output logic [LEN_W-1:0] res_count
);

  logic [LEN_W-1:0] cnt_q;
  logic             fwd;
  err_class_e       cls;

  assign fwd      = ev_waiting && eng_rx_valid && rd_q && (cnt_q < len_q);
  assign rd_valid = fwd;
  assign rd_data  = eng_rx_data;
  assign cls      = status_class(eng_status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_class <= ERR_NONE;
      res_reply <= '0;
      res_count <= '0;
    end else begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      if (ev_start) cnt_q <= '0;
      else if (fwd) cnt_q <= cnt_q + LEN_W'(1);
      if (ev_reject) begin
        res_valid <= 1'b1;
        res_err   <= 1'b1;
        res_class <= ERR_REJECT;
        res_reply <= '0;
        res_count <= '0;
      end else if (ev_waiting && eng_done) begin
        res_valid <= 1'b1;
        res_err   <= (cls != ERR_NONE);
        res_class <= cls;
        if (cls == ERR_NONE) begin
          res_reply <= eng_reply[7:4];
          res_count <= rd_q ? cnt_q : len_q;
        end else begin
          res_reply <= '0;
          res_count <= '0;
        end
      end
    end
  end

  // R7: reported count never exceeds the requested length
  a_r7_clip: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_count <= len_q));

  // R8: an error result carries no count and no reply
  a_r8_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> ((res_count == '0) && (res_reply == '0)));

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_fr_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_cmd,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  input  logic             eng_rx_valid,
  input  logic [7:0]       eng_rx_data,
  input  logic             eng_done,
  input  logic [7:0]       eng_status,
  input  logic [7:0]       eng_reply,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             res_valid,
  output logic             res_err,
  output logic [1:0]       res_class,
  output logic [3:0]       res_reply,
  output logic [LEN_W-1:0] res_count
);

  logic             ev_start;
  logic             ev_reject;
  logic             ev_waiting;
  logic             rd_q;
  logic [LEN_W-1:0] len_q;

  aux_tx_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .eng_done(eng_done),
    .ev_start(ev_start), .ev_reject(ev_reject), .ev_waiting(ev_waiting),
    .rd_q(rd_q), .len_q(len_q)
  );

  aux_rx_dec #(.LEN_W(LEN_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_reject(ev_reject), .ev_waiting(ev_waiting),
    .rd_q(rd_q), .len_q(len_q),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .eng_done(eng_done), .eng_status(eng_status), .eng_reply(eng_reply),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .res_valid(res_valid), .res_err(res_err), .res_class(res_class),
    .res_reply(res_reply), .res_count(res_count)
  );

  // R1: a rejection is reported with nothing sent in the cycle before it
  a_r1_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_class == ERR_REJECT)) |-> $past(!tx_valid));

  // R10: ready comes back together with the result
  a_r10_ready_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> req_ready);

  // R10: the result is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R6: error flag agrees with a non-zero class
  a_r6_err_class: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (res_valid && (res_class != ERR_NONE)));

endmodule

// File: tb/test_aux_req_framer.sv
module test_aux_req_framer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LEN_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [3:0]       req_cmd = '0;
  logic [15:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             wr_valid = 1'b1;
  logic             wr_ready;
  logic [7:0]       wr_data;
  logic             tx_valid;
  logic             tx_ready = 1'b1;
  logic [7:0]       tx_data;
  logic             eng_rx_valid = 1'b0;
  logic [7:0]       eng_rx_data = '0;
  logic             eng_done = 1'b0;
  logic [7:0]       eng_status = '0;
  logic [7:0]       eng_reply = '0;
  logic             rd_valid;
  logic [7:0]       rd_data;
  logic             res_valid;
  logic             res_err;
  logic [1:0]       res_class;
  logic [3:0]       res_reply;
  logic [LEN_W-1:0] res_count;

  int nchk = 0;
  int nerr = 0;

  logic [7:0] wbuf [0:31];
  logic [7:0] txbuf [0:31];
  logic [7:0] rdbuf [0:31];
  int txn = 0, rdn = 0, widx = 0, nres = 0;
  int r_err = 0, r_cls = 0, r_rep = 0, r_cnt = 0;

  always #10 clk = ~clk;

  assign wr_data = wbuf[widx[4:0]];

  aux_req_framer i_aux_req_framer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .eng_done(eng_done), .eng_status(eng_status), .eng_reply(eng_reply),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .res_valid(res_valid), .res_err(res_err), .res_class(res_class),
    .res_reply(res_reply), .res_count(res_count)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready && txn < 32) begin txbuf[txn] = tx_data; txn = txn + 1; end
      if (wr_valid && wr_ready) widx = widx + 1;
      if (rd_valid && rdn < 32) begin rdbuf[rdn] = rd_data; rdn = rdn + 1; end
      if (res_valid) begin
        nres = nres + 1;
        r_err = int'(res_err); r_cls = int'(res_class);
        r_rep = int'(res_reply); r_cnt = int'(res_count);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Expected header byte, derived from the requirement text.
  function automatic int exp_hdr(input int i, input int cmd, input int addr, input int len, input bit rd);
    int hi;
    case (i)
      0: return addr % 256;
      1: return addr / 256;
      2: return cmd * 16;
      default: begin
        if (len == 0) return 8'h30;
        hi = rd ? 4 : ((len + 4) % 16);
        return hi * 16 + (len - 1);
      end
    endcase
  endfunction

  task automatic run(input string tag, input int cmd, input int addr, input int len,
                     input int status, input int reply, input int nrx);
    int  base, ecls, ecnt, erep, etx, erd, guard;
    bit  rd, legal;
    base  = cmd % 16;
    rd    = ((base == 1) || (base == 5) || (base == 9) || (base == 13));
    legal = (base == 0 || base == 1 || base == 4 || base == 5 ||
             base == 8 || base == 9 || base == 12 || base == 13) && (len <= 16);
    etx   = legal ? (4 + (rd ? 0 : len)) : 0;
    ecls  = !legal ? 3 : (status == 1) ? 1 : (status == 2 || status == 3) ? 2 : 0;
    ecnt  = (ecls != 0) ? 0 : (rd ? min2(nrx, len) : len);
    erep  = (ecls != 0) ? 0 : (reply / 16);
    erd   = (legal && rd) ? min2(nrx, len) : 0;

    for (int i = 0; i < 32; i++) wbuf[i] = 8'(8'hA0 + i * 7);
    @(negedge clk);
    txn = 0; rdn = 0; widx = 0; nres = 0;
    req_cmd = 4'(cmd); req_addr = 16'(addr); req_len = LEN_W'(len); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R10 ready low while busy"}, int'(req_ready), 0);

    if (legal) begin
      guard = 0;
      while (txn < etx && guard < 200) begin @(negedge clk); guard++; end
      chk({tag, " R5 header/payload bytes sent"}, txn, etx);
      for (int i = 0; i < nrx; i++) begin
        eng_rx_valid = 1'b1; eng_rx_data = 8'(8'h50 + i);
        @(negedge clk);
      end
      eng_rx_valid = 1'b0;
      eng_done = 1'b1; eng_status = 8'(status); eng_reply = 8'(reply);
      @(negedge clk);
      eng_done = 1'b0;
    end

    guard = 0;
    while (nres == 0 && guard < 200) begin @(negedge clk); guard++; end
    chk({tag, " R10 one result"}, nres, 1);
    chk({tag, " R10 result pulse ends"}, int'(res_valid), 0);
    chk({tag, " R10 ready back"}, int'(req_ready), 1);

    chk({tag, " R1 R5 byte count"}, txn, etx);
    for (int i = 0; i < 4 && i < txn; i++) begin
      if (i < 2)       chk({tag, " R2 address byte"}, int'(txbuf[i]), exp_hdr(i, cmd, addr, len, rd));
      else if (i == 2) chk({tag, " R2 command byte"}, int'(txbuf[i]), exp_hdr(i, cmd, addr, len, rd));
      else begin
        chk({tag, " R3 length low nibble"}, int'(txbuf[i][3:0]), exp_hdr(3, cmd, addr, len, rd) % 16);
        chk({tag, " R4 length high nibble"}, int'(txbuf[i][7:4]), exp_hdr(3, cmd, addr, len, rd) / 16);
      end
    end
    for (int i = 4; i < txn; i++)
      chk({tag, " R5 payload byte"}, int'(txbuf[i]), int'(8'(8'hA0 + (i - 4) * 7)));

    if (legal) chk({tag, " R6 error class"}, r_cls, ecls);
    else       chk({tag, " R9 R1 reject class"}, r_cls, ecls);
    chk({tag, " R6 error flag"}, r_err, (ecls != 0) ? 1 : 0);
    chk({tag, " R8 reply nibble"}, r_rep, erep);
    chk({tag, " R7 R8 count"}, r_cnt, ecnt);
    chk({tag, " R7 forwarded read bytes"}, rdn, erd);
    for (int i = 0; i < rdn && i < erd; i++)
      chk({tag, " R7 read data"}, int'(rdbuf[i]), int'(8'(8'h50 + i)));
  endtask

  task automatic t_reset();
    chk("R11 ready after reset", int'(req_ready), 1);
    chk("R11 tx idle after reset", int'(tx_valid), 0);
    chk("R11 rd idle after reset", int'(rd_valid), 0);
    chk("R11 no result after reset", int'(res_valid), 0);
  endtask

  task automatic t_writes();
    run("native write 3", 8, 16'h1234, 3, 0, 8'h00, 0);
    run("i2c write 16 wrap", 0, 16'h00A5, 16, 4, 8'h20, 0);
    run("i2c write mot bare", 4, 16'h0050, 0, 0, 8'h00, 0);
    run("write 12 ignores rx", 8, 16'h8001, 12, 0, 8'h30, 2);
  endtask

  task automatic t_reads();
    run("native read clip", 9, 16'hBEEF, 2, 0, 8'h10, 4);
    run("i2c read short", 1, 16'h0037, 5, 0, 8'hF0, 3);
    run("i2c read mot bare", 5, 16'h0042, 0, 0, 8'h00, 1);
  endtask

  task automatic t_status();
    run("timeout", 9, 16'h0100, 1, 1, 8'hFF, 0);
    run("flags io", 8, 16'h0200, 2, 2, 8'hFF, 0);
    run("generic io", 1, 16'h0300, 1, 3, 8'hFF, 0);
    run("status 7 ok", 9, 16'h0400, 3, 7, 8'h80, 3);
  endtask

  task automatic t_reject();
    run("too big write", 8, 16'h1111, 17, 0, 0, 0);
    run("too big read mot", 13, 16'h2222, 31, 0, 0, 0);
    run("bad cmd A", 10, 16'h3333, 1, 0, 0, 0);
    run("bad cmd 2", 2, 16'h4444, 0, 0, 0, 0);
    run("after reject write", 12, 16'h5555, 1, 0, 8'h40, 0);
  endtask

  initial begin
    #4_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_writes();
    t_reads();
    t_status();
    t_reject();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule